// File: doc/BRIEF.md
# MDIO Management Master (Clause 22)

This block turns a single 32-bit write into one Clause 22 management frame on an MDC/MDIO pair toward an external PHY. The host writes one command word holding the PHY address, the register number, the direction and (for a write) the data. The block then generates MDC from the system clock through a fixed divider. It shifts the frame out on MDIO and, for a read, releases the line and collects the returned data.

The command register also reports status. While a frame is in flight it shows a busy flag. Once a read has finished, it shows a read-valid flag, and its low half-word then holds the data returned by the PHY. When a frame ends, a done flag is set in an interrupt cause register. An interrupt line is raised when that flag and its enable bit in a separate mask register are both set. Software clears the done flag by writing zero to that bit.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The command register at offset 0x00 takes data in bits 15:0, the PHY address in bits 20:16, the register number in bits 25:21 and the direction in bit 26 (1 = read, 0 = write). After an accepted write, the same fields read back from the same positions.
- R2: Bit 28 of the command register (busy) reads 1 from the clock edge that accepts a command for exactly 128*MDC_HALF clock cycles, and then reads 0.
- R3: MDC is low whenever no frame is in progress. During a frame it runs 64 periods, each MDC_HALF clock cycles low followed by MDC_HALF cycles high, starting low.
- R4: A write frame drives, MSB first: 32 ones, 01, opcode 01, the PHY address, the register number, 10, and the 16 data bits. MDIO changes only while MDC is low, so each bit is stable across the rising edge.
- R5: A read frame drives 32 ones, 01, opcode 10, the PHY address and the register number. It then deasserts the output enable for the remaining 18 bit times, samples MDIO at the last 16 rising MDC edges MSB first, and returns the word in bits 15:0.
- R6: Bit 27 (read valid) becomes 1 when a read frame completes. It is cleared on the edge that accepts any new command, and it stays 0 after a write frame.
- R7: A command write while busy is 1 is ignored: the frame in progress and all stored fields are unchanged.
- R8: Bit 4 of the cause register at offset 0x7C becomes 1 when a frame (read or write) ends.
- R9: Writing a word with bit 4 = 0 to offset 0x7C clears the done flag. Writing bit 4 = 1 leaves it as it was.
- R10: The mask register at offset 0x80 stores bit 4 and reads it back at bit 4. The irq output is 1 exactly when the done flag and the mask bit are both 1.
- R11: After reset, all three registers read 0, and mdc, mdio_oe and irq are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Operation-done interrupt |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench builds the block with MDC_HALF = 2, so a full frame takes 256 clock cycles. At that length, several reads and writes, a mid-frame command collision and the full interrupt sequence all fit in a short run. The exact busy length and the MDC high time can still be counted cycle by cycle against 128*MDC_HALF and 64*MDC_HALF. The small divider also keeps the PHY responder's falling-edge drive and the block's rising-edge sample close together, which exercises the turnaround timing.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int PHY_W     = 5;
  localparam int REG_W     = 5;
  localparam int DAT_W     = 16;
  localparam int FRAME_LEN = 64;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int RELEASE_AT = 46;   // first bit time the PHY owns in a read
  localparam int SAMPLE_AT  = 48;   // first sampled data bit
  localparam int OFS_CMD   = 'h00;
  localparam int OFS_CAUSE = 'h7C;
  localparam int OFS_MASK  = 'h80;
  localparam int B_OP      = 26;
  localparam int B_VALID   = 27;
  localparam int B_BUSY    = 28;
  localparam int B_DONE    = 4;

  // Value of bit time idx of a frame (MSB-first assembly of the whole frame)
  function automatic logic frame_bit(input logic [IDX_W-1:0] idx,
                                     input logic is_rd,
                                     input logic [PHY_W-1:0] phy,
                                     input logic [REG_W-1:0] ra,
                                     input logic [DAT_W-1:0] wd);
    logic [FRAME_LEN-1:0] fr;
    fr = {32'hFFFF_FFFF, 2'b01, is_rd, ~is_rd, phy, ra, 2'b10, wd};
    return fr[IDX_W'(FRAME_LEN-1) - idx];
  endfunction

  // Whether the master owns the line during bit time idx
  function automatic logic master_drives(input logic [IDX_W-1:0] idx,
                                         input logic is_rd);
    return !(is_rd && (idx >= IDX_W'(RELEASE_AT)));
  endfunction
endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
  parameter int MDC_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick     = run && (cnt == CW'(MDC_HALF - 1));
  assign rise_evt = tick && !mdc;
  assign fall_evt = tick && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_rd,
  input  logic [PHY_W-1:0] phy,
  input  logic [REG_W-1:0] ra,
  input  logic [DAT_W-1:0] wd,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  logic             mdio_i,
  output logic             busy,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             frame_done,
  output logic [DAT_W-1:0] rx_data
);
  logic [IDX_W-1:0] idx;
  logic             last_bit;
  logic             sample_now;

  assign last_bit   = (idx == IDX_W'(FRAME_LEN - 1));
  assign frame_done = busy && fall_evt && last_bit;
  assign sample_now = busy && rise_evt && is_rd && (idx >= IDX_W'(SAMPLE_AT));
  assign mdio_o     = busy && frame_bit(idx, is_rd, phy, ra, wd);
  assign mdio_oe    = busy && master_drives(idx, is_rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      rx_data <= '0;
    end else begin
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy && fall_evt) begin
        if (last_bit) busy <= 1'b0;
        else          idx  <= idx + IDX_W'(1);
      end
      if (sample_now) rx_data <= {rx_data[DAT_W-2:0], mdio_i};
    end
  end
endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  input  logic              busy,
  input  logic              frame_done,
  input  logic [DAT_W-1:0]  rx_data,
  output logic [31:0]       reg_rdata,
  output logic              start,
  output logic              is_rd,
  output logic [PHY_W-1:0]  phy,
  output logic [REG_W-1:0]  ra,
  output logic [DAT_W-1:0]  wd,
  output logic              rd_valid,
  output logic              irq_cause,
  output logic              irq_mask,
  output logic              irq
);
  logic sel_cmd, sel_cause, sel_mask;

  assign sel_cmd   = (reg_addr == ADDR_W'(OFS_CMD));
  assign sel_cause = (reg_addr == ADDR_W'(OFS_CAUSE));
  assign sel_mask  = (reg_addr == ADDR_W'(OFS_MASK));
  assign start     = reg_we && sel_cmd && !busy;
  assign irq       = irq_cause && irq_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_rd     <= 1'b0;
      phy       <= '0;
      ra        <= '0;
      wd        <= '0;
      rd_valid  <= 1'b0;
      irq_cause <= 1'b0;
      irq_mask  <= 1'b0;
    end else begin
      if (start) begin
        wd       <= reg_wdata[DAT_W-1:0];
        phy      <= reg_wdata[DAT_W +: PHY_W];
        ra       <= reg_wdata[DAT_W+PHY_W +: REG_W];
        is_rd    <= reg_wdata[B_OP];
        rd_valid <= 1'b0;
      end else if (frame_done && is_rd) begin
        wd       <= rx_data;
        rd_valid <= 1'b1;
      end
      if (frame_done)
        irq_cause <= 1'b1;
      else if (reg_we && sel_cause && !reg_wdata[B_DONE])
        irq_cause <= 1'b0;
      if (reg_we && sel_mask) irq_mask <= reg_wdata[B_DONE];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_cmd) begin
      reg_rdata[DAT_W-1:0]             = wd;
      reg_rdata[DAT_W +: PHY_W]        = phy;
      reg_rdata[DAT_W+PHY_W +: REG_W]  = ra;
      reg_rdata[B_OP]                  = is_rd;
      reg_rdata[B_VALID]               = rd_valid;
      reg_rdata[B_BUSY]                = busy;
    end else if (sel_cause) begin
      reg_rdata[B_DONE] = irq_cause;
    end else if (sel_mask) begin
      reg_rdata[B_DONE] = irq_mask;
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int MDC_HALF = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic             busy, start, frame_done, rise_evt, fall_evt;
  logic             is_rd, rd_valid, irq_cause, irq_mask;
  logic [PHY_W-1:0] phy;
  logic [REG_W-1:0] ra;
  logic [DAT_W-1:0] wd, rx_data;

  mdio_csr #(.ADDR_W(ADDR_W)) csr_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .busy(busy), .frame_done(frame_done),
    .rx_data(rx_data), .reg_rdata(reg_rdata), .start(start),
    .is_rd(is_rd), .phy(phy), .ra(ra), .wd(wd), .rd_valid(rd_valid),
    .irq_cause(irq_cause), .irq_mask(irq_mask), .irq(irq)
  );

  mdio_mdc_div #(.MDC_HALF(MDC_HALF)) div_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .mdc(mdc),
    .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_seq seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .is_rd(is_rd), .phy(phy),
    .ra(ra), .wd(wd), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .mdio_i(mdio_i), .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .frame_done(frame_done), .rx_data(rx_data)
  );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_HALF = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             frame_done,
  input logic             irq,
  input logic             irq_cause,
  input logic             irq_mask,
  input logic             rd_valid,
  input logic             is_rd,
  input logic [PHY_W-1:0] phy,
  input logic [REG_W-1:0] ra
);
  logic [31:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_cnt <= '0;
    else                 busy_cnt <= busy_cnt + 32'd1;
  end

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == 32'(128 * MDC_HALF)));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  p_hold_while_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

  p_valid_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !rd_valid);

  p_fields_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(phy) && $stable(ra) && $stable(is_rd)));

  p_done_sets_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> irq_cause);

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_mask && irq_cause));
endmodule

bind mdio_mgmt_master mdio_mgmt_checker #(.MDC_HALF(MDC_HALF)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .frame_done(frame_done), .irq(irq),
  .irq_cause(irq_cause), .irq_mask(irq_mask), .rd_valid(rd_valid),
  .is_rd(is_rd), .phy(phy), .ra(ra)
);

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_mgmt_master_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int HALF = 2;
  localparam int FRAME_CYC = 128 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0, n_fail = 0;
  int rises = 0, base = 0;
  logic [63:0] cap = '0, cap_oe = '0;
  logic [15:0] resp = '0;
  int kk;

  always #2.5 clk = ~clk;

  mdio_mgmt_master #(.ADDR_W(8), .MDC_HALF(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY responder: records the line at each rising MDC, answers reads
  always @(posedge mdc) begin
    cap    = {cap[62:0], mdio_o};
    cap_oe = {cap_oe[62:0], mdio_oe};
    rises  = rises + 1;
  end

  always @(negedge mdc) begin
    kk = rises - base;
    if (kk == 47)                  mdio_i = 1'b0;
    else if (kk >= 48 && kk <= 63) mdio_i = resp[63 - kk];
    else                           mdio_i = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] cmd_word(input logic rd, input logic [4:0] p,
                                           input logic [4:0] r, input logic [15:0] d);
    return {5'b0, rd, r, p, d};
  endfunction

  // Launch a command and follow busy until it drops
  task automatic run_frame(input logic [31:0] cmd, output int bcyc, output int hcyc,
                           output int nr);
    base = rises;
    reg_wr(8'h00, cmd);
    reg_addr = 8'h00;
    bcyc = 0; hcyc = 0;
    for (int g = 0; g < 4 * FRAME_CYC; g++) begin
      #1;
      if (!reg_rdata[28]) break;
      bcyc++;
      if (mdc) hcyc++;
      @(negedge clk);
    end
    nr = rises - base;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_rd(8'h00, v); chk(v == 0, "R11 cmd reg", v, 0);
    reg_rd(8'h7C, v); chk(v == 0, "R11 cause reg", v, 0);
    reg_rd(8'h80, v); chk(v == 0, "R11 mask reg", v, 0);
    chk({mdc, mdio_oe, irq} == 3'b000, "R11 pins", {mdc, mdio_oe, irq}, 0);
  endtask

  task automatic t_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    int bc, hc, nr;
    logic [31:0] v;
    logic [63:0] exp;
    run_frame(cmd_word(1'b0, p, r, d), bc, hc, nr);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
    chk(bc == FRAME_CYC, "R2 busy length write", 64'(bc), 64'(FRAME_CYC));
    chk(hc == 64 * HALF && nr == 64, "R3 mdc high time and periods",
        {32'(hc), 32'(nr)}, {32'(64 * HALF), 32'd64});
    chk(cap == exp, "R4 write frame bits", cap, exp);
    chk(cap_oe == '1, "R4 write drives all bits", cap_oe, '1);
    reg_rd(8'h00, v);
    chk(v == cmd_word(1'b0, p, r, d), "R1 R6 write readback", v, cmd_word(1'b0, p, r, d));
    reg_rd(8'h7C, v); chk(v == 32'h10, "R8 cause after write", v, 32'h10);
    reg_wr(8'h7C, 32'hFFFF_FFEF);
    reg_rd(8'h7C, v); chk(v == 0, "R9 cleared by zero", v, 0);
  endtask

  task automatic t_read(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    int bc, hc, nr;
    logic [31:0] v;
    logic [63:0] exp;
    resp = d;
    run_frame(cmd_word(1'b1, p, r, 16'h0000), bc, hc, nr);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 18'b0};
    chk(bc == FRAME_CYC, "R2 busy length read", 64'(bc), 64'(FRAME_CYC));
    chk(cap[63:18] == exp[63:18], "R5 read header bits", cap, exp);
    chk(cap_oe == 64'hFFFF_FFFF_FFFC_0000, "R5 release pattern", cap_oe,
        64'hFFFF_FFFF_FFFC_0000);
    reg_rd(8'h00, v);
    chk(v == (cmd_word(1'b1, p, r, d) | 32'h0800_0000), "R5 R6 read data and valid", v,
        cmd_word(1'b1, p, r, d) | 32'h0800_0000);
    reg_wr(8'h7C, 32'h0);
  endtask

  task automatic t_valid_clear();
    logic [31:0] v;
    int bc, hc, nr;
    reg_wr(8'h00, cmd_word(1'b0, 5'd1, 5'd1, 16'h1234));
    reg_rd(8'h00, v);
    chk(v[28:27] == 2'b10, "R6 valid cleared on new command", v[28:27], 2'b10);
    run_frame(32'h0, bc, hc, nr);   // waits out the frame; the extra write is ignored or runs
    reg_wr(8'h7C, 32'h0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    logic [63:0] exp;
    base = rises;
    reg_wr(8'h00, cmd_word(1'b0, 5'h0C, 5'h03, 16'hBEEF));
    repeat (100) @(negedge clk);
    reg_wr(8'h00, cmd_word(1'b1, 5'h1F, 5'h1F, 16'h0F0F));
    reg_addr = 8'h00;
    for (int g = 0; g < 4 * FRAME_CYC; g++) begin
      #1;
      if (!reg_rdata[28]) break;
      @(negedge clk);
    end
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h0C, 5'h03, 2'b10, 16'hBEEF};
    chk(cap == exp, "R7 frame unchanged by busy write", cap, exp);
    reg_rd(8'h00, v);
    chk(v == cmd_word(1'b0, 5'h0C, 5'h03, 16'hBEEF), "R7 fields unchanged", v,
        cmd_word(1'b0, 5'h0C, 5'h03, 16'hBEEF));
    repeat (4) @(negedge clk);
    chk(!mdc && !mdio_oe, "R7 no second frame started", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    int bc, hc, nr;
    run_frame(cmd_word(1'b0, 5'd2, 5'd4, 16'h0), bc, hc, nr);
    #1 chk(irq == 1'b0, "R10 masked irq low", irq, 0);
    reg_wr(8'h7C, 32'hFFFF_FFFF);
    reg_rd(8'h7C, v); chk(v == 32'h10, "R9 write one keeps cause", v, 32'h10);
    reg_wr(8'h80, 32'h0000_0010);
    reg_rd(8'h80, v); chk(v == 32'h10, "R10 mask readback", v, 32'h10);
    chk(irq == 1'b1, "R10 irq when cause and mask", irq, 1);
    reg_wr(8'h7C, 32'h0);
    #1 chk(irq == 1'b0, "R9 R10 irq drops after clear", irq, 0);
    reg_wr(8'h80, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write(5'h11, 5'h0A, 16'hA5C3);
    t_write(5'h00, 5'h1F, 16'h0001);
    t_read(5'h03, 5'h02, 16'h8001);
    t_read(5'h1F, 5'h00, 16'h7E5A);
    t_valid_clear();
    t_busy_ignore();
    t_irq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule